// File: doc/BRIEF.md
# Extended multiply/divide unit

A multicycle arithmetic unit for a 16-bit accumulator machine. It carries out the wide multiply and divide operations. A one-cycle start pulse, together with a 2-bit operation code, launches one of four operations:

- a signed 16-bit by 16-bit divide;
- an unsigned divide of a 32-bit dividend by a 16-bit divisor;
- the signed form of that 32-bit by 16-bit divide;
- a signed 16x16 multiply.

The operands are the current values of the accumulator D and the index registers X and Y. The unit returns the complete updated D, X and Y values. Registers that an operation does not write are passed through unchanged. It also returns carry, zero, negative and overflow flag values, each with its own update enable, and a one-cycle done strobe.

Divides use a restoring shift-subtract engine. The engine produces one quotient bit per clock over a 32-bit dividend. Signed divides run on magnitudes and restore the signs at the end. Quotients truncate toward zero, and a remainder takes the sign of its dividend. The multiply is formed in a single cycle. A divide with a zero divisor also completes in one cycle, because nothing needs to be computed.

Top module: `xmd_unit`

## Requirements
- R1: While reset is high, and after it is released until the first start, busy, done, D/X/Y outputs, flag values and flag enables are all 0.
- R2: Opcode 2'b00 divides signed D by signed X. X receives the quotient, truncated toward zero, and D receives the remainder, which has the sign of D. Y passes through. V is 1 only when the quotient does not fit a signed 16-bit value (-32768 / -1).
- R3: Opcode 2'b01 divides the unsigned 32-bit value {Y,D} (Y upper) by unsigned X. Y receives the low 16 quotient bits and D the remainder. X passes through. V is 1 when the quotient exceeds 0xFFFF.
- R4: Opcode 2'b10 divides the signed 32-bit value {Y,D} by signed X, with the same register roles as R3. V is 1 when the quotient lies outside -32768..32767.
- R5: For any divide with X equal to 0, D, X and Y come back unchanged. C is 1 with only the C enable high.
- R6: A divide with a nonzero divisor raises all four enables. C is 0, Z is 1 exactly when the full quotient is 0, and N equals quotient bit 15.
- R7: Opcode 2'b11 multiplies signed D by signed Y. Y receives product bits 31:16 and D receives bits 15:0; X passes through. Z flags a zero product, N is bit 31 and C is bit 15. The V enable stays 0.
- R8: busy rises in the cycle after an accepted start. A start seen while busy is ignored and does not change the running operation's result.
- R9: done is high for exactly one cycle, which is the cycle in which new D/X/Y values first appear. It comes 2W+1 cycles after the start edge for a divide with a nonzero divisor, and 1 cycle after it otherwise. Flag enables are high only when done is high, and a flag value whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only while idle |
| op_i | input | 2 | Operation code (see R2, R3, R4, R7) |
| d_i | input | W | Current D register |
| x_i | input | W | Current X register |
| y_i | input | W | Current Y register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| d_o | output | W | Updated D register |
| x_o | output | W | Updated X register |
| y_o | output | W | Updated Y register |
| c_o | output | 1 | Carry flag value |
| z_o | output | 1 | Zero flag value |
| n_o | output | 1 | Negative flag value |
| v_o | output | 1 | Overflow flag value |
| c_we | output | 1 | Carry flag update enable |
| z_we | output | 1 | Zero flag update enable |
| n_we | output | 1 | Negative flag update enable |
| v_we | output | 1 | Overflow flag update enable |

## Verification
The assertions check the following on every cycle:

- done is a one-cycle pulse that never overlaps busy, and register outputs change only together with done;
- a start taken while idle raises busy;
- the flag enable patterns are consistent: a zero-divisor completion shows only C set, and a successful divide clears C;
- a multiply completion's Z, N and C agree with the product shown on Y and D.

The assertions cannot observe the operation code, so only the bench's sweeps can show the actual quotients, remainders, truncation and remainder signs, the overflow boundaries, the pass-through registers and the completion latency. The bench computes these against an arithmetic model over corner and pseudo-random operands. It also shows that a start held high during a running divide is ignored.

// File: rtl/xmd_pkg.sv
package xmd_pkg;

  typedef enum logic [1:0] {
    OP_SDIV16 = 2'b00,
    OP_UDIV32 = 2'b01,
    OP_SDIV32 = 2'b10,
    OP_SMUL   = 2'b11
  } xmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_DIV   = 2'b01,
    ST_QUICK = 2'b10
  } xmd_state_e;

endpackage

// File: rtl/xmd_divcore.sv
// Restoring divider: 2W-bit unsigned dividend by W-bit unsigned divisor,
// one quotient bit per clock. The quotient shifts into the dividend register.
module xmd_divcore #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic           fin_o,
  output logic [2*W-1:0] quo_o,
  output logic [W-1:0]   rem_o
);
  localparam int NB = 2 * W;
  localparam int CW = $clog2(NB);

  logic [NB-1:0] acc;
  logic [W-1:0]  part;
  logic [W-1:0]  dvs;
  logic [CW-1:0] cnt;
  logic          run;
  logic          fin;

  logic [W:0] shifted;
  logic [W:0] diff;
  logic       ge;

  always_comb begin
    shifted = {part, acc[NB-1]};
    diff    = shifted - {1'b0, dvs};
    ge      = shifted >= {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      part <= '0;
      dvs  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        acc  <= dvd_i;
        part <= '0;
        dvs  <= dvs_i;
        cnt  <= '0;
        run  <= 1'b1;
      end else if (run) begin
        acc  <= {acc[NB-2:0], ge};
        part <= ge ? diff[W-1:0] : shifted[W-1:0];
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(NB - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign fin_o = fin;
  assign quo_o = acc;
  assign rem_o = part;

endmodule

// File: rtl/xmd_mul.sv
// Signed W x W multiply, full 2W-bit product.
module xmd_mul #(
  parameter int W = 16
) (
  input  logic signed [W-1:0]   a_i,
  input  logic signed [W-1:0]   b_i,
  output logic signed [2*W-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/xmd_result.sv
// Forms the updated registers and flag values/enables for a finished operation.
module xmd_result
  import xmd_pkg::*;
#(
  parameter int W = 16
) (
  input  xmd_op_e        op_i,
  input  logic           dz_i,
  input  logic [W-1:0]   d_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic [2*W-1:0] quo_i,
  input  logic [W-1:0]   rem_i,
  input  logic           qneg_i,
  input  logic           rneg_i,
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0]   d_o,
  output logic [W-1:0]   x_o,
  output logic [W-1:0]   y_o,
  output logic [3:0]     fval_o,
  output logic [3:0]     fen_o
);
  // flag vectors are ordered {C, Z, N, V}
  logic [2*W:0] qext;
  logic [2*W:0] qsig;
  logic [W-1:0] rsig;
  logic [W+1:0] qhi;
  logic         sfit;

  always_comb begin
    qext = {1'b0, quo_i};
    qsig = qneg_i ? (~qext + 1'b1) : qext;
    rsig = rneg_i ? (~rem_i + 1'b1) : rem_i;
    qhi  = qsig[2*W:W-1];
    sfit = (qhi == '0) || (&qhi);
  end

  always_comb begin
    d_o    = d_i;
    x_o    = x_i;
    y_o    = y_i;
    fval_o = 4'b0000;
    fen_o  = 4'b0000;
    if (dz_i && op_i != OP_SMUL) begin
      fval_o = 4'b1000;
      fen_o  = 4'b1000;
    end else begin
      unique case (op_i)
        OP_SDIV16: begin
          x_o    = qsig[W-1:0];
          d_o    = rsig;
          fen_o  = 4'b1111;
          fval_o = {1'b0, qsig == '0, qsig[W-1], ~sfit};
        end
        OP_UDIV32: begin
          y_o    = quo_i[W-1:0];
          d_o    = rem_i;
          fen_o  = 4'b1111;
          fval_o = {1'b0, quo_i == '0, quo_i[W-1], |quo_i[2*W-1:W]};
        end
        OP_SDIV32: begin
          y_o    = qsig[W-1:0];
          d_o    = rsig;
          fen_o  = 4'b1111;
          fval_o = {1'b0, qsig == '0, qsig[W-1], ~sfit};
        end
        default: begin
          d_o    = prod_i[W-1:0];
          y_o    = prod_i[2*W-1:W];
          fen_o  = 4'b1110;
          fval_o = {prod_i[W-1], prod_i == '0, prod_i[2*W-1], 1'b0};
        end
      endcase
    end
  end

endmodule

// File: rtl/xmd_unit.sv
module xmd_unit
  import xmd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] d_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         c_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o,
  output logic         c_we,
  output logic         z_we,
  output logic         n_we,
  output logic         v_we
);
  localparam int NB = 2 * W;

  xmd_state_e state;
  xmd_op_e    op_in;
  xmd_op_e    op_q;
  logic [W-1:0] d_q, x_q, y_q;
  logic qneg_q, rneg_q, dz_q;

  // operand preparation (magnitudes and result signs)
  logic [NB-1:0] yd, ydmag, dvd;
  logic [W-1:0]  dmag, xmag, dvs;
  logic dneg, xneg, ydneg, qneg, rneg, is_div, dz, take, load;

  always_comb begin
    op_in = xmd_op_e'(op_i);
    dneg  = d_i[W-1];
    xneg  = x_i[W-1];
    yd    = {y_i, d_i};
    ydneg = y_i[W-1];
    dmag  = dneg ? (~d_i + 1'b1) : d_i;
    xmag  = xneg ? (~x_i + 1'b1) : x_i;
    ydmag = ydneg ? (~yd + 1'b1) : yd;
    dvd   = yd;
    dvs   = x_i;
    qneg  = 1'b0;
    rneg  = 1'b0;
    unique case (op_in)
      OP_SDIV16: begin
        dvd  = {{W{1'b0}}, dmag};
        dvs  = xmag;
        qneg = dneg ^ xneg;
        rneg = dneg;
      end
      OP_SDIV32: begin
        dvd  = ydmag;
        dvs  = xmag;
        qneg = ydneg ^ xneg;
        rneg = ydneg;
      end
      default: ;
    endcase
    is_div = (op_in != OP_SMUL);
    dz     = is_div && (x_i == '0);
    take   = start && (state == ST_IDLE);
    load   = take && is_div && !dz;
  end

  logic           core_fin;
  logic [NB-1:0]  core_quo;
  logic [W-1:0]   core_rem;

  xmd_divcore #(.W(W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .dvd_i (dvd),
    .dvs_i (dvs),
    .fin_o (core_fin),
    .quo_o (core_quo),
    .rem_o (core_rem)
  );

  logic signed [NB-1:0] prod;

  xmd_mul #(.W(W)) u_mul (
    .a_i (d_q),
    .b_i (y_q),
    .p_o (prod)
  );

  logic [W-1:0] r_d, r_x, r_y;
  logic [3:0]   r_fval, r_fen;

  xmd_result #(.W(W)) u_res (
    .op_i   (op_q),
    .dz_i   (dz_q),
    .d_i    (d_q),
    .x_i    (x_q),
    .y_i    (y_q),
    .quo_i  (core_quo),
    .rem_i  (core_rem),
    .qneg_i (qneg_q),
    .rneg_i (rneg_q),
    .prod_i (prod),
    .d_o    (r_d),
    .x_o    (r_x),
    .y_o    (r_y),
    .fval_o (r_fval),
    .fen_o  (r_fen)
  );

  logic finish;
  assign finish = (state == ST_QUICK) || (state == ST_DIV && core_fin);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= OP_SDIV16;
      d_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      dz_q   <= 1'b0;
      d_o    <= '0;
      x_o    <= '0;
      y_o    <= '0;
      {c_o, z_o, n_o, v_o}     <= 4'b0000;
      {c_we, z_we, n_we, v_we} <= 4'b0000;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      {c_o, z_o, n_o, v_o}     <= 4'b0000;
      {c_we, z_we, n_we, v_we} <= 4'b0000;
      if (take) begin
        op_q   <= op_in;
        d_q    <= d_i;
        x_q    <= x_i;
        y_q    <= y_i;
        qneg_q <= qneg;
        rneg_q <= rneg;
        dz_q   <= dz;
        state  <= load ? ST_DIV : ST_QUICK;
      end
      if (finish) begin
        d_o   <= r_d;
        x_o   <= r_x;
        y_o   <= r_y;
        {c_o, z_o, n_o, v_o}     <= r_fval;
        {c_we, z_we, n_we, v_we} <= r_fen;
        done  <= 1'b1;
        state <= ST_IDLE;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/xmd_unit_chk.sv
module xmd_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] d_o,
  input logic [W-1:0] x_o,
  input logic [W-1:0] y_o,
  input logic         c_o,
  input logic         z_o,
  input logic         n_o,
  input logic         c_we,
  input logic         z_we,
  input logic         n_we,
  input logic         v_we
);
  // R9: done lasts one cycle
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: completion leaves the unit idle
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: register outputs move only together with done
  a_r9_regs_with_done: assert property (@(posedge clk) disable iff (rst)
    !$stable({d_o, x_o, y_o}) |-> done);

  // R9: flag enables only with done
  a_r9_enables_with_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> !(c_we || z_we || n_we || v_we));

  // R8: an accepted start makes the unit busy
  a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R5: zero-divisor completion writes only C, set to 1
  a_r5_zero_divisor_flags: assert property (@(posedge clk) disable iff (rst)
    (done && c_we && !z_we) |-> (c_o && !n_we && !v_we));

  // R6: a successful divide clears C and writes every flag
  a_r6_divide_clears_c: assert property (@(posedge clk) disable iff (rst)
    (done && v_we) |-> (c_we && !c_o && z_we && n_we));

  // R7: multiply flags agree with the product on Y:D
  a_r7_mul_flags: assert property (@(posedge clk) disable iff (rst)
    (done && z_we && !v_we) |->
      ((z_o == ({y_o, d_o} == '0)) && (n_o == y_o[W-1]) && (c_o == d_o[W-1])));

endmodule

bind xmd_unit xmd_unit_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .d_o   (d_o),
  .x_o   (x_o),
  .y_o   (y_o),
  .c_o   (c_o),
  .z_o   (z_o),
  .n_o   (n_o),
  .c_we  (c_we),
  .z_we  (z_we),
  .n_we  (n_we),
  .v_we  (v_we)
);

// File: tb/xmd_unit_tb.sv
`timescale 1ns/1ps
module xmd_unit_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [W-1:0] d_i = '0, x_i = '0, y_i = '0;
  logic busy, done;
  logic [W-1:0] d_o, x_o, y_o;
  logic c_o, z_o, n_o, v_o, c_we, z_we, n_we, v_we;

  int tests = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #4 clk = ~clk;

  xmd_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_i(op_i),
    .d_i(d_i), .x_i(x_i), .y_i(y_i),
    .busy(busy), .done(done), .d_o(d_o), .x_o(x_o), .y_o(y_o),
    .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o),
    .c_we(c_we), .z_we(z_we), .n_we(n_we), .v_we(v_we)
  );

  function automatic logic [15:0] corner(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h0003;
      4: return 16'h7FFF;
      5: return 16'h8000;
      6: return 16'hFFFE;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic rnd(output logic [15:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed[15:0];
  endtask

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // Drives one operation from a negedge; disturb keeps start high with junk.
  task automatic run_op(input logic [1:0] op, input logic [15:0] d,
                        input logic [15:0] x, input logic [15:0] y,
                        input bit disturb);
    longint a, b, q, r, p;
    logic [15:0] ed, ex, ey;
    logic [7:0] ef, gf;
    int lat, n;
    string tag;
    ed = d; ex = x; ey = y; ef = '0; lat = 2 * W + 2;
    q = 0; r = 0; p = 0;
    if (op != 2'b11 && x == 16'h0) begin
      ef = 8'b1000_1000; lat = 2; tag = "R5";
    end else begin
      case (op)
        2'b00: begin
          a = longint'($signed(d)); b = longint'($signed(x));
          q = a / b; r = a % b;
          ex = q[15:0]; ed = r[15:0];
          ef = {1'b0, q == 0, q[15], (q > 32767 || q < -32768), 4'b1111};
          tag = "R2/R6";
        end
        2'b01: begin
          a = longint'({y, d}); b = longint'(x);
          q = a / b; r = a % b;
          ey = q[15:0]; ed = r[15:0];
          ef = {1'b0, q == 0, q[15], q > 65535, 4'b1111};
          tag = "R3/R6";
        end
        2'b10: begin
          a = longint'($signed({y, d})); b = longint'($signed(x));
          q = a / b; r = a % b;
          ey = q[15:0]; ed = r[15:0];
          ef = {1'b0, q == 0, q[15], (q > 32767 || q < -32768), 4'b1111};
          tag = "R4/R6";
        end
        default: begin
          p = longint'($signed(d)) * longint'($signed(y));
          ed = p[15:0]; ey = p[31:16];
          ef = {p[15], p == 0, p[31], 1'b0, 4'b1110};
          lat = 2; tag = "R7";
        end
      endcase
    end
    op_i = op; d_i = d; x_i = x; y_i = y; start = 1'b1;
    @(negedge clk);
    n = 1;
    if (!disturb) start = 1'b0;
    while (!done && n < 100) begin
      if (disturb && n == 3) begin
        check(busy == 1'b1, $sformatf("R8 busy got %0b exp 1", busy));
        op_i = 2'b11; d_i = 16'h1357; x_i = 16'h0000; y_i = 16'hBEEF;
      end
      if (disturb && n == 6) start = 1'b0;
      @(negedge clk);
      n++;
    end
    check(n == lat, $sformatf("R9 latency got %0d exp %0d", n, lat));
    check({d_o, x_o, y_o} == {ed, ex, ey},
          $sformatf("%s op%0d regs got %h %h %h exp %h %h %h (d=%h x=%h y=%h)",
                    tag, op, d_o, x_o, y_o, ed, ex, ey, d, x, y));
    gf = {c_o, z_o, n_o, v_o, c_we, z_we, n_we, v_we};
    check(gf == ef, $sformatf("%s op%0d flags got %b exp %b (d=%h x=%h y=%h)",
                              tag, op, gf, ef, d, x, y));
    @(negedge clk);
    check(done == 1'b0 && {c_we, z_we, n_we, v_we} == 4'b0,
          $sformatf("R9 done pulse got %0b exp 0", done));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R9 watchdog: got no end, exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd, rx, ry;
    repeat (3) @(negedge clk);
    check({busy, done, d_o, x_o, y_o, c_o, z_o, n_o, v_o, c_we, z_we, n_we, v_we} == '0,
          $sformatf("R1 reset outputs got busy=%0b done=%0b d=%h exp all 0", busy, done, d_o));
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && d_o == '0,
          $sformatf("R1 after release got busy=%0b done=%0b exp 0", busy, done));

    // R2/R7: 16-bit operands, corner sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        run_op(2'b00, corner(i), corner(j), 16'hA5A5, 1'b0);
        run_op(2'b11, corner(i), 16'h5A5A, corner(j), 1'b0);
      end
    // R3/R4/R5: 32-bit dividends, corner sweep
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++) begin
          run_op(2'b01, corner(i), corner(j), corner(k), 1'b0);
          run_op(2'b10, corner(i), corner(j), corner(k), 1'b0);
        end
    // pseudo-random operands for every opcode
    for (int t = 0; t < 150; t++)
      for (int o = 0; o < 4; o++) begin
        rnd(rd); rnd(rx); rnd(ry);
        if (o == 1) ry = ry % (rx | 16'h1);
        run_op(2'(o), rd, rx, ry, 1'b0);
      end
    // R8: start held high with other operands during a running divide
    run_op(2'b01, 16'h4321, 16'h0007, 16'h0005, 1'b1);
    run_op(2'b10, 16'h0001, 16'hFFF9, 16'h8000, 1'b1);
    run_op(2'b00, 16'h8000, 16'hFFFF, 16'h0000, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule